// File: doc/BRIEF.md
# Reloadable Overflow Interval Timer

This block is an up-counting interval timer on a simple synchronous register bus. Software sets a start value. The counter then counts upward one step per clock and overflows when it passes the all-ones value. On overflow the timer sets a sticky status flag, which drives the interrupt line when the interrupt is enabled. The counter then either reloads from a load register and keeps running, or clears to zero and stops.

To get a period of P clocks, software writes the all-ones value minus (P − 1) into the load register and into the counter. It then sets the run and reload bits.

A posted mode makes writes to the control, counter and load registers take effect a fixed number of clocks after the bus write. While such a write is still in flight, a per-register pending flag is visible to software. A second write to the same register while its flag is still set replaces the first one. In non-posted mode those writes take effect on the next clock edge, and the counter can be read back live at any time.

Top module: `reload_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Register offsets are control 0x00, counter 0x04, load 0x08, interrupt status 0x0C, interrupt enable 0x10 and write-pending 0x14. In the control register, bit 0 is run and bit 1 is auto-reload. While run is 1, the counter increases by one on every clock.
- R3: When the counter overflows from all-ones with auto-reload 0, the counter becomes 0 and run clears, so the counter stays at 0 afterwards.
- R4: When the counter overflows with auto-reload 1, the counter takes the load value and run stays set. With load value all-ones minus N, overflow repeats every N+1 clocks.
- R5: An overflow sets bit 0 of the interrupt status register. Writing 1 to that bit clears it, and writing 0 leaves it unchanged. A new overflow in the same cycle as a clear wins.
- R6: `irq` is high exactly when status bit 0 and interrupt-enable bit 0 are both 1.
- R7: Writing run = 0 freezes the counter at its present value.
- R8: With `postedMode` low, a write to control, counter or load is visible on the next clock edge, and reading the counter returns its live value.
- R9: With `postedMode` high, a write to control, counter or load takes effect POST_DELAY clocks after the write edge. Until then the write-pending register holds a 1 for it: bit 0 for control, bit 1 for counter, bit 2 for load.
- R10: In posted mode, a second write to a register whose pending bit is still set discards the earlier data and restarts that register's delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| postedMode | input | 1 | Selects delayed (posted) register writes |
| busAddr | input | ADDR_W | Byte offset of the accessed register |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | DATA_W | Write data |
| busRdData | output | DATA_W | Read data for `busAddr`, combinational |
| irq | output | 1 | Overflow interrupt, level |

## Verification
The assertions assume that `postedMode` changes only while no write is pending. They also assume that each bus write is a single-cycle strobe. The bench flips the mode only after it has seen the pending register read zero, and it drives every write through one task that holds `busWrEn` for exactly one edge. Overflow timing is checked by counting edges from the edge on which the run bit landed, so every expected counter value follows from the load arithmetic alone.

// File: rtl/reload_timer_pkg.sv
package reload_timer_pkg;
  localparam int unsigned OFS_CTRL   = 'h00;
  localparam int unsigned OFS_COUNT  = 'h04;
  localparam int unsigned OFS_LOAD   = 'h08;
  localparam int unsigned OFS_STATUS = 'h0C;
  localparam int unsigned OFS_ENABLE = 'h10;
  localparam int unsigned OFS_PEND   = 'h14;

  localparam int unsigned NUM_POSTED = 3;
  localparam int unsigned IDX_CTRL   = 0;
  localparam int unsigned IDX_COUNT  = 1;
  localparam int unsigned IDX_LOAD   = 2;

  typedef struct packed {
    logic applyCtrl;
    logic applyCount;
    logic applyLoad;
  } tmrStrobe_t;
endpackage

// File: rtl/reload_timer_ctrl.sv
module reload_timer_ctrl
  import reload_timer_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 5,
  parameter int POST_DELAY = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              postedMode,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              irq,
  output tmrStrobe_t        strobe,
  output logic [1:0]        ctrlData,
  output logic [DATA_W-1:0] countData,
  output logic [DATA_W-1:0] loadData,
  input  logic              ovfPulse,
  input  logic [1:0]        ctrlBits,
  input  logic [DATA_W-1:0] countVal,
  input  logic [DATA_W-1:0] loadVal
);
  localparam int CNT_W = $clog2(POST_DELAY + 1);

  logic [NUM_POSTED-1:0] wrSel;
  logic [NUM_POSTED-1:0] applyVec;
  logic [NUM_POSTED-1:0] pending;
  logic [DATA_W-1:0]     applyData [NUM_POSTED];
  logic                  ovfStatus;
  logic                  ovfEnable;

  assign wrSel[IDX_CTRL]  = busWrEn && (busAddr == ADDR_W'(OFS_CTRL));
  assign wrSel[IDX_COUNT] = busWrEn && (busAddr == ADDR_W'(OFS_COUNT));
  assign wrSel[IDX_LOAD]  = busWrEn && (busAddr == ADDR_W'(OFS_LOAD));

  for (genvar i = 0; i < NUM_POSTED; i++) begin : gPost
    logic [DATA_W-1:0] holdData;
    logic [CNT_W-1:0]  holdCnt;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        holdData <= '0;
        holdCnt  <= '0;
      end else if (postedMode && wrSel[i]) begin
        holdData <= busWrData;
        holdCnt  <= CNT_W'(POST_DELAY);
      end else if (holdCnt != '0) begin
        holdCnt <= holdCnt - 1'b1;
      end
    end

    assign pending[i]   = (holdCnt != '0);
    assign applyVec[i]  = postedMode ? (holdCnt == CNT_W'(1) && !wrSel[i]) : wrSel[i];
    assign applyData[i] = postedMode ? holdData : busWrData;

    // R9: a posted write raises its pending bit
    assert_pend_set_R9: assert property (@(posedge clk) disable iff (!rstN)
      (postedMode && wrSel[i]) |=> pending[i]);
    // R10: a rewrite while pending holds off the apply strobe
    assert_rewrite_defers_R10: assert property (@(posedge clk) disable iff (!rstN)
      (postedMode && wrSel[i]) |=> !applyVec[i]);
  end

  assign strobe.applyCtrl  = applyVec[IDX_CTRL];
  assign strobe.applyCount = applyVec[IDX_COUNT];
  assign strobe.applyLoad  = applyVec[IDX_LOAD];
  assign ctrlData  = applyData[IDX_CTRL][1:0];
  assign countData = applyData[IDX_COUNT];
  assign loadData  = applyData[IDX_LOAD];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovfStatus <= 1'b0;
      ovfEnable <= 1'b0;
    end else begin
      if (ovfPulse) begin
        ovfStatus <= 1'b1;
      end else if (busWrEn && busAddr == ADDR_W'(OFS_STATUS) && busWrData[0]) begin
        ovfStatus <= 1'b0;
      end
      if (busWrEn && busAddr == ADDR_W'(OFS_ENABLE)) begin
        ovfEnable <= busWrData[0];
      end
    end
  end

  assign irq = ovfStatus & ovfEnable;

  always_comb begin
    busRdData = '0;
    case (busAddr)
      ADDR_W'(OFS_CTRL):   busRdData = DATA_W'(ctrlBits);
      ADDR_W'(OFS_COUNT):  busRdData = countVal;
      ADDR_W'(OFS_LOAD):   busRdData = loadVal;
      ADDR_W'(OFS_STATUS): busRdData = DATA_W'(ovfStatus);
      ADDR_W'(OFS_ENABLE): busRdData = DATA_W'(ovfEnable);
      ADDR_W'(OFS_PEND):   busRdData = DATA_W'(pending);
      default:             busRdData = '0;
    endcase
  end

  // R5: an overflow always leaves the status flag set
  assert_status_set_R5: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |=> ovfStatus);
  // R6: the interrupt line never rises without the enable bit
  assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (ovfEnable && ovfStatus));
  // R8: non-posted writes never leave anything pending
  assert_no_pend_direct_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!postedMode && $past(!postedMode) && !$past(pending[IDX_LOAD])) |-> !pending[IDX_LOAD]);
endmodule

// File: rtl/reload_timer_datapath.sv
module reload_timer_datapath
  import reload_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobe_t        strobe,
  input  logic [1:0]        ctrlData,
  input  logic [DATA_W-1:0] countData,
  input  logic [DATA_W-1:0] loadData,
  output logic              ovfPulse,
  output logic [1:0]        ctrlBits,
  output logic [DATA_W-1:0] countVal,
  output logic [DATA_W-1:0] loadVal
);
  logic runBit;
  logic reloadBit;

  assign ctrlBits = {reloadBit, runBit};
  assign ovfPulse = runBit && (countVal == '1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runBit    <= 1'b0;
      reloadBit <= 1'b0;
    end else if (strobe.applyCtrl) begin
      runBit    <= ctrlData[0];
      reloadBit <= ctrlData[1];
    end else if (ovfPulse && !reloadBit) begin
      runBit <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countVal <= '0;
    end else if (strobe.applyCount) begin
      countVal <= countData;
    end else if (ovfPulse) begin
      countVal <= reloadBit ? loadVal : '0;
    end else if (runBit) begin
      countVal <= countVal + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadVal <= '0;
    end else if (strobe.applyLoad) begin
      loadVal <= loadData;
    end
  end

  // R2: a running counter steps by exactly one
  assert_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (runBit && !ovfPulse && !strobe.applyCount) |=> countVal == $past(countVal) + 1'b1);
  // R3: one-shot overflow stops and zeroes the counter
  assert_oneshot_stop_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ovfPulse && !reloadBit && !strobe.applyCtrl && !strobe.applyCount) |=> (!runBit && countVal == '0));
  // R4: periodic overflow reloads and keeps running
  assert_reload_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ovfPulse && reloadBit && !strobe.applyCtrl && !strobe.applyCount) |=> (runBit && countVal == $past(loadVal)));
  // R7: a stopped counter holds its value
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!runBit && !strobe.applyCount) |=> $stable(countVal));
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import reload_timer_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 5,
  parameter int POST_DELAY = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              postedMode,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              irq
);
  tmrStrobe_t        strobe;
  logic [1:0]        ctrlData;
  logic [DATA_W-1:0] countData;
  logic [DATA_W-1:0] loadData;
  logic              ovfPulse;
  logic [1:0]        ctrlBits;
  logic [DATA_W-1:0] countVal;
  logic [DATA_W-1:0] loadVal;

  reload_timer_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .POST_DELAY(POST_DELAY)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .postedMode(postedMode),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(busRdData), .irq(irq),
    .strobe(strobe), .ctrlData(ctrlData), .countData(countData), .loadData(loadData),
    .ovfPulse(ovfPulse), .ctrlBits(ctrlBits), .countVal(countVal), .loadVal(loadVal)
  );

  reload_timer_datapath #(
    .DATA_W(DATA_W)
  ) uData (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .ctrlData(ctrlData), .countData(countData), .loadData(loadData),
    .ovfPulse(ovfPulse), .ctrlBits(ctrlBits), .countVal(countVal), .loadVal(loadVal)
  );
endmodule

// File: tb/tb_reload_timer.sv
module tb_reload_timer;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 5;
  localparam int POST_DELAY = 3;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              postedMode = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic              busWrEn = 1'b0;
  logic [DATA_W-1:0] busWrData = '0;
  logic [DATA_W-1:0] busRdData;
  logic              irq;

  int checks = 0;
  int errors = 0;

  reload_timer #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .POST_DELAY(POST_DELAY)) dut (
    .clk(clk), .rstN(rstN), .postedMode(postedMode), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input int addr, input logic [DATA_W-1:0] data);
    @(negedge clk);
    busAddr = ADDR_W'(addr);
    busWrData = data;
    busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic checkReg(input string tag, input int addr, input logic [DATA_W-1:0] exp);
    busAddr = ADDR_W'(addr);
    #1;
    check(tag, busRdData, exp);
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    checkReg("R1 ctrl", 'h00, 0);
    checkReg("R1 count", 'h04, 0);
    checkReg("R1 load", 'h08, 0);
    checkReg("R1 status", 'h0C, 0);
    checkReg("R1 pending", 'h14, 0);
    check("R1 irq", DATA_W'(irq), 0);
  endtask

  task automatic testOneShot();
    busWrite('h04, 32'hFFFF_FFFD);
    busWrite('h00, 32'h1);
    checkReg("R8 live count", 'h04, 32'hFFFF_FFFD);
    waitEdges(1);
    checkReg("R2 step", 'h04, 32'hFFFF_FFFE);
    waitEdges(2);
    checkReg("R3 wrap zero", 'h04, 0);
    checkReg("R3 run cleared", 'h00, 0);
    checkReg("R5 status set", 'h0C, 1);
    check("R6 irq masked", DATA_W'(irq), 0);
    waitEdges(2);
    checkReg("R3 stays zero", 'h04, 0);
  endtask

  task automatic testStatusIrq();
    busWrite('h0C, 0);
    checkReg("R5 write0 no effect", 'h0C, 1);
    busWrite('h10, 1);
    check("R6 irq enabled", DATA_W'(irq), 1);
    busWrite('h0C, 1);
    checkReg("R5 w1c", 'h0C, 0);
    check("R6 irq cleared", DATA_W'(irq), 0);
  endtask

  task automatic testReload();
    busWrite('h08, 32'hFFFF_FFFC);
    busWrite('h04, 32'hFFFF_FFFC);
    busWrite('h00, 32'h3);
    waitEdges(4);
    checkReg("R4 reloaded", 'h04, 32'hFFFF_FFFC);
    checkReg("R4 keeps running", 'h00, 3);
    check("R6 irq on overflow", DATA_W'(irq), 1);
    waitEdges(1);
    checkReg("R4 continues", 'h04, 32'hFFFF_FFFD);
    waitEdges(3);
    checkReg("R4 second period", 'h04, 32'hFFFF_FFFC);
    busWrite('h0C, 1);
    busWrite('h00, 0);
    begin
      logic [DATA_W-1:0] held;
      busAddr = ADDR_W'('h04);
      #1;
      held = busRdData;
      waitEdges(3);
      checkReg("R7 frozen", 'h04, held);
    end
  endtask

  task automatic testPosted();
    @(negedge clk);
    postedMode = 1'b1;
    busWrite('h08, 32'h0000_1234);
    checkReg("R9 load pending", 'h14, 4);
    checkReg("R9 load not yet", 'h08, 32'hFFFF_FFFC);
    waitEdges(2);
    checkReg("R9 still pending", 'h14, 4);
    waitEdges(1);
    checkReg("R9 pending clear", 'h14, 0);
    checkReg("R9 load landed", 'h08, 32'h0000_1234);
    busWrite('h04, 32'h55);
    checkReg("R9 count pending bit", 'h14, 2);
    waitEdges(3);
    checkReg("R9 count landed", 'h04, 32'h55);
  endtask

  task automatic testDiscard();
    busWrite('h08, 32'hAAAA_AAAA);
    busWrite('h08, 32'hBBBB_BBBB);
    waitEdges(1);
    checkReg("R10 first discarded", 'h08, 32'h0000_1234);
    checkReg("R10 still pending", 'h14, 4);
    waitEdges(2);
    checkReg("R10 second landed", 'h08, 32'hBBBB_BBBB);
    checkReg("R10 pending clear", 'h14, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testOneShot();
    testStatusIrq();
    testReload();
    testPosted();
    testDiscard();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule